// File: doc/BRIEF.md
# Smart Shutdown Fault Sequencer

This block is the digital fault-handling core of a half-bridge gate driver. It sits on a shared, bidirectional shutdown line. That line has an external pull-up and a timing capacitor. The block receives a flag from the overcurrent comparator and a supply-undervoltage flag. It also receives two digitized views of the shared line: one that says the line is below the lower input threshold, and one that says it is above the upper threshold. It drives two outputs. The first is an open-drain pull-down enable for the line. The second is an output-enable that gates both power-stage drivers.

When a qualified fault arrives, the output-enable drops in the same cycle through a direct combinational path. The block does not wait for the line voltage to fall. At the same time the sequencer turns on the pull-down and discharges the external capacitor. Once the line is seen below the lower threshold, the sequencer releases the pull-down so the pull-up can recharge the line. Drive resumes only when the line climbs above the upper threshold. As a result, the external RC sets the disable time without adding any delay to the protection path.

A low forced on the line from outside is not latched. The enable simply follows the line with hysteresis, which permits PWM chopping through the shutdown line. A sticky flag records that a fault shutdown has occurred, and it stays set until it is cleared.

Top module: `sdn_fault_seq`

## Requirements
- R1: While reset is high, and directly after it, `pd_en_o`, `drv_en_o` and `fault_seen_o` are 0. After reset the enable stays 0 while the line sits between thresholds (`line_lo_i`=0, `line_hi_i`=0).
- R2: A qualified fault (`flt_cmp_i`=1 with `uv_lock_i`=0) forces `drv_en_o` to 0 in the same cycle, before any clock edge, whatever the line levels.
- R3: On a qualified fault, `pd_en_o` goes to 1 at the next rising clock edge. It stays 1 for as long as the line is not seen below the lower threshold.
- R4: The pull-down is released once `line_lo_i`=1 has passed the SYNC_STAGES-deep synchronizer (with the default of 2, at the third rising edge after the input changes) and no qualified fault is present. `drv_en_o` stays 0 after the release.
- R5: After a fault release, `drv_en_o` returns to 1 only after `line_hi_i`=1 has passed the synchronizer (third edge by default). A line held between the thresholds keeps the enable at 0.
- R6: With no fault present, an external low (`line_lo_i`=1) clears `drv_en_o` at the third edge and leaves `pd_en_o` at 0. The shutdown is not latched: a later high level restores the enable.
- R7: The enable has hysteresis. While it is on, a line between the thresholds keeps it on. While it is off after an external low, a line between the thresholds keeps it off.
- R8: A qualified fault while the block is recovering, or while it is off because of an external low, turns the pull-down on again at the next edge.
- R9: While `uv_lock_i`=1 the comparator flag is ignored. The pull-down stays off, the sticky flag is not set, and `drv_en_o` is not affected.
- R10: `fault_seen_o` becomes 1 at the edge after a qualified fault and holds until `stat_clr_i`=1 at an edge clears it. If a qualified fault and a clear arrive together, the fault wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_cmp_i | input | 1 | Fault comparator flag, 1 = fault |
| uv_lock_i | input | 1 | Supply undervoltage lockout, 1 = locked out |
| line_lo_i | input | 1 | Shared line below the lower threshold |
| line_hi_i | input | 1 | Shared line above the upper threshold |
| stat_clr_i | input | 1 | Clears the sticky fault flag |
| pd_en_o | output | 1 | Open-drain pull-down enable for the shared line |
| drv_en_o | output | 1 | Enable gating both half-bridge drivers |
| fault_seen_o | output | 1 | Sticky flag: a fault shutdown has occurred |

## Verification
If the sequencer holds the wrong state, `pd_en_o` shows it first. A pull-down that is not released keeps the line low forever and the enable never returns. A pull-down that is released early shows up one edge after the fault, long before the line has crossed the lower threshold. A lost hysteresis state shows up as `drv_en_o` toggling while the line sits between thresholds, exactly three edges after a level change. A broken direct path shows up as `drv_en_o` still high in the half cycle after a fault, before any edge.

// File: rtl/sdn_pkg.sv
package sdn_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_PULL  = 2'd1,
    ST_RECOV = 2'd2,
    ST_EXT   = 2'd3
  } sdn_state_e;
endpackage

// File: rtl/sdn_sync.sv
module sdn_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdn_fsm.sv
module sdn_fsm
  import sdn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fault_act,
  input  logic       lo_s,
  input  logic       hi_s,
  output logic       pd_q,
  output logic       en_q,
  output sdn_state_e state_o
);
  sdn_state_e state_q, nxt;
  logic       hi_clean;

  assign hi_clean = hi_s && !lo_s;

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_RECOV: begin
        if (fault_act)     nxt = ST_PULL;
        else if (hi_clean) nxt = ST_RUN;
      end
      ST_RUN: begin
        if (fault_act)     nxt = ST_PULL;
        else if (lo_s)     nxt = ST_EXT;
      end
      ST_EXT: begin
        if (fault_act)     nxt = ST_PULL;
        else if (hi_clean) nxt = ST_RUN;
      end
      ST_PULL: begin
        if (lo_s && !fault_act) nxt = ST_RECOV;
      end
      default: nxt = ST_RECOV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RECOV;
      pd_q    <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= nxt;
      pd_q    <= (nxt == ST_PULL);
      en_q    <= (nxt == ST_RUN);
    end
  end

  assign state_o = state_q;

  AST_PD_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    fault_act |=> pd_q); // R3
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PULL && !lo_s) |=> pd_q); // R3
  AST_PD_REL_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_q) |-> $past(lo_s)); // R4
  AST_EN_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(hi_s)); // R5
  AST_EXT_NO_PD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !fault_act) |=> !pd_q); // R6
  AST_PD_ONLY_FAULT: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_q) |-> $past(fault_act)); // R9
endmodule

// File: rtl/sdn_status.sv
module sdn_status (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic sticky_o
);
  logic sticky_q;

  always_ff @(posedge clk) begin
    if (rst)        sticky_q <= 1'b0;
    else if (set_i) sticky_q <= 1'b1;
    else if (clr_i) sticky_q <= 1'b0;
  end

  assign sticky_o = sticky_q;

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    set_i |=> sticky_q); // R10
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sticky_q && !clr_i) |=> sticky_q); // R10
endmodule

// File: rtl/sdn_fault_seq.sv
module sdn_fault_seq
  import sdn_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flt_cmp_i,
  input  logic uv_lock_i,
  input  logic line_lo_i,
  input  logic line_hi_i,
  input  logic stat_clr_i,
  output logic pd_en_o,
  output logic drv_en_o,
  output logic fault_seen_o
);
  localparam int LVL_W = 2;

  logic [LVL_W-1:0] lvl_raw, lvl_s;
  logic             fault_act;
  logic             pd_q, en_q;
  sdn_state_e       state;

  assign lvl_raw   = {line_hi_i, line_lo_i};
  assign fault_act = flt_cmp_i && !uv_lock_i;

  sdn_sync #(.STAGES(SYNC_STAGES), .WIDTH(LVL_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (lvl_raw),
    .q   (lvl_s)
  );

  sdn_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .fault_act (fault_act),
    .lo_s      (lvl_s[0]),
    .hi_s      (lvl_s[1]),
    .pd_q      (pd_q),
    .en_q      (en_q),
    .state_o   (state)
  );

  sdn_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_i    (fault_act),
    .clr_i    (stat_clr_i),
    .sticky_o (fault_seen_o)
  );

  assign pd_en_o  = pd_q;
  assign drv_en_o = en_q && !fault_act;

  AST_EN_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
    drv_en_o |-> (state == ST_RUN)); // R2
endmodule

// File: tb/sdn_fault_seq_tb.sv
module sdn_fault_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flt = 1'b0, uv = 1'b0, lo = 1'b0, hi = 1'b0, clr = 1'b0;
  logic pd_en, drv_en, seen;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  typedef struct {
    logic  pd;
    logic  en;
    logic  st;
    string tag;
  } exp_t;
  exp_t sb [$];

  always #2 clk = ~clk;

  sdn_fault_seq u_dut (
    .clk          (clk),
    .rst          (rst),
    .flt_cmp_i    (flt),
    .uv_lock_i    (uv),
    .line_lo_i    (lo),
    .line_hi_i    (hi),
    .stat_clr_i   (clr),
    .pd_en_o      (pd_en),
    .drv_en_o     (drv_en),
    .fault_seen_o (seen)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // Monitor: one expected item per clock, compared just after the edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(pd_en,  e.pd, {e.tag, " pd_en_o"});
      chk(drv_en, e.en, {e.tag, " drv_en_o"});
      chk(seen,   e.st, {e.tag, " fault_seen_o"});
    end
  end

  // Driver: apply inputs at the falling edge, queue the expected outputs
  // after the next rising edge.
  task automatic step(input logic l, input logic h, input logic f,
                      input logic u, input logic c,
                      input logic epd, input logic een, input logic est,
                      input string tag);
    exp_t e;
    @(negedge clk);
    lo = l; hi = h; flt = f; uv = u; clr = c;
    e.pd = epd; e.en = een; e.st = est; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) step(0,0,0,0,0, 0,0,0, "R1 in reset");
    @(negedge clk); rst = 1'b0;
    repeat (4) step(0,0,0,0,0, 0,0,0, "R1 mid after reset");
    step(0,1,0,0,0, 0,0,0, "R1 hi sync1");
    step(0,1,0,0,0, 0,0,0, "R1 hi sync2");
    step(0,1,0,0,0, 0,1,0, "R1 hi enables");
    // R7 hysteresis in run
    repeat (4) step(0,0,0,0,0, 0,1,0, "R7 mid keeps on");
    // R6 external low, not latched
    step(1,0,0,0,0, 0,1,0, "R6 ext low s1");
    step(1,0,0,0,0, 0,1,0, "R6 ext low s2");
    step(1,0,0,0,0, 0,0,0, "R6 ext low off");
    step(1,0,0,0,0, 0,0,0, "R6 ext low no pd");
    repeat (3) step(0,0,0,0,0, 0,0,0, "R7 mid keeps off");
    step(0,1,0,0,0, 0,0,0, "R6 hi s1");
    step(0,1,0,0,0, 0,0,0, "R6 hi s2");
    step(0,1,0,0,0, 0,1,0, "R6 re-enabled");
    // PWM chopping through the line
    for (int k = 0; k < 2; k++) begin
      step(1,0,0,0,0, 0,1,0, "R6 pwm low s1");
      step(1,0,0,0,0, 0,1,0, "R6 pwm low s2");
      step(1,0,0,0,0, 0,0,0, "R6 pwm low");
      step(0,1,0,0,0, 0,0,0, "R6 pwm high s1");
      step(0,1,0,0,0, 0,0,0, "R6 pwm high s2");
      step(0,1,0,0,0, 0,1,0, "R6 pwm high");
    end
    // Fault: immediate disable, pull-down hold
    step(0,1,1,0,0, 1,0,1, "R3 fault pd on");
    #1 chk(drv_en, 1'b0, "R2 direct disable before edge");
    repeat (4) step(0,1,0,0,0, 1,0,1, "R3 hold line high");
    repeat (3) step(0,0,0,0,0, 1,0,1, "R3 hold line mid");
    step(1,0,0,0,0, 1,0,1, "R4 low s1");
    step(1,0,0,0,0, 1,0,1, "R4 low s2");
    step(1,0,0,0,0, 0,0,1, "R4 released");
    step(1,0,0,0,0, 0,0,1, "R4 stays off");
    repeat (4) step(0,0,0,0,0, 0,0,1, "R5 mid stays off");
    // R8 fault during recovery
    step(0,0,1,0,0, 1,0,1, "R8 fault in recover");
    repeat (3) step(0,0,0,0,0, 1,0,1, "R8 pd held");
    step(1,0,0,0,0, 1,0,1, "R4 low s1");
    step(1,0,0,0,0, 1,0,1, "R4 low s2");
    step(1,0,0,0,0, 0,0,1, "R4 released again");
    repeat (3) step(0,0,0,0,0, 0,0,1, "R5 mid off");
    step(0,1,0,0,0, 0,0,1, "R5 hi s1");
    step(0,1,0,0,0, 0,0,1, "R5 hi s2");
    step(0,1,0,0,0, 0,1,1, "R5 re-enabled");
    // R10 clear and priority
    step(0,1,0,0,1, 0,1,0, "R10 clear");
    step(0,1,0,0,0, 0,1,0, "R10 stays clear");
    step(0,1,1,0,1, 1,0,1, "R10 fault beats clear");
    step(1,0,0,0,0, 1,0,1, "R4 low s1");
    step(1,0,0,0,0, 1,0,1, "R4 low s2");
    step(1,0,0,0,0, 0,0,1, "R4 released");
    step(0,1,0,0,0, 0,0,1, "R5 hi s1");
    step(0,1,0,0,0, 0,0,1, "R5 hi s2");
    step(0,1,0,0,0, 0,1,1, "R5 on");
    step(0,1,0,0,1, 0,1,0, "R10 clear");
    // R9 undervoltage masks the comparator
    step(0,1,1,1,0, 0,1,0, "R9 uv fault ignored");
    #1 chk(drv_en, 1'b1, "R9 enable unaffected before edge");
    step(0,1,1,1,0, 0,1,0, "R9 uv fault ignored");
    step(0,1,0,0,0, 0,1,0, "R9 after uv");
    // R8 fault during external shutdown
    step(1,0,0,0,0, 0,1,0, "R6 low s1");
    step(1,0,0,0,0, 0,1,0, "R6 low s2");
    step(1,0,0,0,0, 0,0,0, "R6 off");
    step(1,0,1,0,0, 1,0,1, "R8 fault in ext sd");
    step(1,0,0,0,0, 0,0,1, "R4 low already seen");
    step(0,0,0,0,0, 0,0,1, "R5 mid off");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule